// File: doc/BRIEF.md
# 32 kHz Synchronisation Counter Peripheral

This peripheral keeps a free-running up-counter that moves forward once for every pulse of a 32768 Hz tick enable. The tick enable is a single-cycle strobe that is already synchronous to the bus clock. After reset the counter reads as the number of ticks seen since reset. Software reads the counter through a small read-only register window, which also holds a constant identification register.

Reads can be word-wide or halfword-wide. A halfword read of a lower half captures the matching upper half in a holding register. A later halfword read of any upper half then returns that captured value, so a 32-bit count can be put together without tearing. Byte accesses, reserved sizes, writes of any kind and unknown word offsets raise the error flag.

Read data and the error flag are registered. They appear on the cycle after the access strobe and return to zero on the next idle cycle.

Top module: `sync32k_timer`

## Requirements
- R1: After reset the counter, the holding register, `rdata` and `err` are all zero.
- R2: The counter goes up by exactly one on each clock edge where `tick_en` is high, and keeps its value otherwise.
- R3: The counter rolls over from its all-ones value to zero with no side effect.
- R4: A word read (`size` = 2'b10) at offset 0x00 returns 0x00000021 with `err` low.
- R5: A word read at offset 0x10 returns the count held on the clock edge where the strobe is taken, with `err` low.
- R6: A halfword read (`size` = 2'b01) with address bit 1 clear returns the low 16 bits of the addressed register and stores its high 16 bits in the holding register. Offset 0x00 stores 0 and offset 0x10 stores count[31:16]. Any other such address raises `err`, returns 0 and stores 0.
- R7: A halfword read with address bit 1 set returns the holding register in bits 15:0 at any address, with `err` low. It does not sample the live counter and does not change the holding register.
- R8: A read of size byte (2'b00) or reserved (2'b11) raises `err`, returns 0 and changes no state.
- R9: Any write (`wr_en` high, which takes priority over `rd_en`) raises `err`, returns 0 and changes neither the counter nor the holding register. This holds for every size and address.
- R10: A word read at any offset other than 0x00 or 0x10 raises `err` and returns 0.
- R11: `rdata` and `err` are valid exactly one cycle after a strobe. On a cycle that follows no strobe, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32768 Hz advance pulse, one clock wide |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the access |
| size | input | 2 | Access width: 00 byte, 01 halfword, 10 word, 11 reserved |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Registered access error flag |

## Verification
The bench builds the block with ADDR_W = 6 and COUNT_W = 17. The narrow address lets every offset be swept under every access size and under both reads and writes. The narrow counter puts count bit 16 within reach at 65536 ticks, so a tear-free halfword pair is exercised across a real upper-half change. The full rollover at 131072 ticks also fits inside one run, with the tick held high.

// File: rtl/sync32k_pkg.sv
package sync32k_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;

    localparam logic [DATA_W-1:0] REV_ID = 32'h0000_0021;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_REV  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_HOLD = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic    err;
        rd_sel_e sel;
        logic    half_lo;
        logic    hold_load;
    } dec_s;

endpackage

// File: rtl/sync32k_counter.sv
module sync32k_counter #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    output logic [COUNT_W-1:0] count_o
);

    localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);
    localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
    } cnt_state_s;

    cnt_state_s state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (tick_en) begin
            state_d.cnt = state_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.cnt;

    // R2
    tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (count_o == $past(count_o) + CNT_ONE));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count_o));

    // R3
    rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && count_o == CNT_MAX) |=> (count_o == '0));

endmodule

// File: rtl/sync32k_decode.sv
module sync32k_decode
    import sync32k_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REV_OFS = ADDR_W'('h00),
    parameter logic [ADDR_W-1:0] CNT_OFS = ADDR_W'('h10)
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output dec_s              dec_o
);

    logic hit_rev;
    logic hit_cnt;
    logic hi_half;

    assign hit_rev = (addr == REV_OFS);
    assign hit_cnt = (addr == CNT_OFS);
    assign hi_half = addr[1];

    always_comb begin
        dec_o           = '0;
        dec_o.sel       = SEL_ZERO;
        if (wr_en) begin
            dec_o.err = 1'b1;
        end else if (rd_en) begin
            unique case (acc_size_e'(size))
                SZ_HALF: begin
                    if (hi_half) begin
                        dec_o.sel = SEL_HOLD;
                    end else begin
                        dec_o.half_lo   = 1'b1;
                        dec_o.hold_load = 1'b1;
                        if (hit_rev) begin
                            dec_o.sel = SEL_REV;
                        end else if (hit_cnt) begin
                            dec_o.sel = SEL_CNT;
                        end else begin
                            dec_o.err = 1'b1;
                        end
                    end
                end
                SZ_WORD: begin
                    if (hit_rev) begin
                        dec_o.sel = SEL_REV;
                    end else if (hit_cnt) begin
                        dec_o.sel = SEL_CNT;
                    end else begin
                        dec_o.err = 1'b1;
                    end
                end
                default: begin
                    dec_o.err = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/sync32k_rdpath.sv
module sync32k_rdpath
    import sync32k_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  dec_s              dec_i,
    input  logic [DATA_W-1:0] count_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic [HALF_W-1:0] hold;
    } rd_state_s;

    rd_state_s         state_d, state_q;
    logic [DATA_W-1:0] word_val;

    always_comb begin
        unique case (dec_i.sel)
            SEL_REV:  word_val = REV_ID;
            SEL_CNT:  word_val = count_i;
            default:  word_val = '0;
        endcase
    end

    always_comb begin
        state_d       = state_q;
        state_d.err   = dec_i.err;
        if (dec_i.sel == SEL_HOLD) begin
            state_d.rdata = {{(DATA_W-HALF_W){1'b0}}, state_q.hold};
        end else if (dec_i.half_lo) begin
            state_d.rdata = {{(DATA_W-HALF_W){1'b0}}, word_val[HALF_W-1:0]};
        end else begin
            state_d.rdata = word_val;
        end
        if (dec_i.hold_load) begin
            state_d.hold = word_val[DATA_W-1:HALF_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o = state_q.rdata;
    assign err_o   = state_q.err;

    // R7
    hold_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i.sel == SEL_HOLD) |=>
            (!err_o && rdata_o == {{(DATA_W-HALF_W){1'b0}}, $past(state_q.hold)}));

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_i.hold_load |=> $stable(state_q.hold));

    // R8
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i.err |=> (err_o && rdata_o == '0));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_i.err && dec_i.sel == SEL_ZERO) |=> (!err_o && rdata_o == '0));

endmodule

// File: rtl/sync32k_timer.sv
module sync32k_timer
    import sync32k_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int COUNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [31:0]       rdata,
    output logic              err
);

    localparam logic [ADDR_W-1:0] REV_OFS = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] CNT_OFS = ADDR_W'('h10);

    logic [COUNT_W-1:0] count;
    logic [DATA_W-1:0]  count_word;
    dec_s               dec;

    sync32k_counter #(
        .COUNT_W (COUNT_W)
    ) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count_o (count)
    );

    generate
        if (COUNT_W >= DATA_W) begin : g_full
            assign count_word = count[DATA_W-1:0];
        end else begin : g_pad
            assign count_word = {{(DATA_W-COUNT_W){1'b0}}, count};
        end
    endgenerate

    sync32k_decode #(
        .ADDR_W  (ADDR_W),
        .REV_OFS (REV_OFS),
        .CNT_OFS (CNT_OFS)
    ) decode_i (
        .rd_en (rd_en),
        .wr_en (wr_en),
        .addr  (addr),
        .size  (size),
        .dec_o (dec)
    );

    sync32k_rdpath rdpath_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_i   (dec),
        .count_i (count_word),
        .rdata_o (rdata),
        .err_o   (err)
    );

    // R4
    rev_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && size == 2'b10 && addr == REV_OFS) |=>
            (!err && rdata == REV_ID));

    // R5
    cnt_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && size == 2'b10 && addr == CNT_OFS) |=>
            (!err && rdata == $past(count_word)));

    // R9
    write_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (err && rdata == '0));

    // R10
    bad_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && size == 2'b10 && addr != REV_OFS && addr != CNT_OFS) |=>
            (err && rdata == '0));

endmodule

// File: tb/sync32k_timer_tb.sv
module sync32k_timer_tb_top;

    localparam int ADDR_W  = 6;
    localparam int COUNT_W = 17;
    localparam logic [31:0] CMASK = (32'h1 << COUNT_W) - 32'h1;

    logic              clk;
    logic              rst_n;
    logic              tick_en;
    logic              rd_en;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        size;
    logic [31:0]       rdata;
    logic              err;

    logic [31:0] cnt_m;
    logic [15:0] hold_m;
    int          checks;
    int          errors;
    bit          done;

    sync32k_timer #(
        .ADDR_W  (ADDR_W),
        .COUNT_W (COUNT_W)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .size    (size),
        .rdata   (rdata),
        .err     (err)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // arithmetic model of elapsed ticks
    always @(posedge clk) begin
        if (!rst_n) cnt_m <= 32'h0;
        else if (tick_en) cnt_m <= (cnt_m + 32'h1) & CMASK;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit rd, input bit wr, input int sz, input int a, input string force_tag);
        logic [31:0] ed;
        logic [31:0] wv;
        bit          ee;
        logic [15:0] nh;
        string       tag;
        @(negedge clk);
        check("R11 idle data", rdata, 32'h0);
        check("R11 idle err", {31'h0, err}, 32'h0);
        rd_en = rd; wr_en = wr; size = sz[1:0]; addr = a[ADDR_W-1:0];
        ed = 32'h0; ee = 1'b0; nh = hold_m; tag = "R9";
        if (!wr) begin
            case (sz)
                1: begin
                    if (a[1]) begin
                        ed = {16'h0, hold_m}; tag = "R7";
                    end else begin
                        wv  = (a == 0) ? 32'h21 : (a == 16) ? cnt_m : 32'h0;
                        ee  = !(a == 0 || a == 16);
                        ed  = {16'h0, wv[15:0]};
                        nh  = wv[31:16];
                        tag = "R6";
                    end
                end
                2: begin
                    if (a == 0) begin ed = 32'h21; tag = "R4"; end
                    else if (a == 16) begin ed = cnt_m; tag = "R5"; end
                    else begin ee = 1'b1; tag = "R10"; end
                end
                default: begin ee = 1'b1; tag = "R8"; end
            endcase
        end else begin
            ee = 1'b1;
        end
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check({tag, " data"}, rdata, ed);
        check({tag, " err"}, {31'h0, err}, {31'h0, ee});
        hold_m = nh;
    endtask

    initial begin
        checks = 0; errors = 0; done = 1'b0; hold_m = 16'h0;
        rst_n = 1'b0; tick_en = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        addr = '0; size = 2'b00;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 reset data", rdata, 32'h0);
        check("R1 reset err", {31'h0, err}, 32'h0);
        rst_n = 1'b1;
        access(1, 0, 2, 16, "R1");
        access(1, 0, 1, 18, "R1");

        // counter frozen without ticks
        access(1, 0, 2, 16, "R2");
        access(1, 0, 2, 16, "R2");
        tick_en = 1'b1;
        access(1, 0, 2, 16, "R2");
        access(1, 0, 2, 16, "R2");

        // sweep every size and offset for reads, then writes
        for (int w = 0; w < 2; w++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int a = 0; a < (1 << ADDR_W); a++) begin
                    access(w == 0, w == 1, sz, a, "");
                end
            end
        end
        // holding register untouched by writes
        access(1, 0, 1, 16, "");
        access(0, 1, 1, 18, "R9");
        access(1, 0, 1, 18, "R9");

        // tear-free pair across upper-half change
        while (cnt_m != 32'h0000_FFFD) @(negedge clk);
        access(1, 0, 1, 16, "R6");
        repeat (6) @(negedge clk);
        access(1, 0, 1, 2, "R7");
        access(1, 0, 2, 16, "R5");
        access(1, 0, 1, 16, "R6");
        access(1, 0, 1, 18, "R7");

        // rollover
        while (cnt_m != CMASK - 32'h1) @(negedge clk);
        access(1, 0, 2, 16, "R3");
        access(1, 0, 2, 16, "R3");
        access(1, 0, 1, 16, "R3");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule